// File: doc/BRIEF.md
# Sub-dword operand selector

This block prepares one source operand for a vector ALU lane. It takes a 32-bit source word and cuts out a byte, a 16-bit half or the whole word, chosen by a select code. The field is right-justified. Optional modifiers then act on it: sign extension, negation and absolute value. How each modifier behaves depends on an operand-kind tag that marks the operand as an unsigned integer, a signed integer or a floating-point value. The sign position that every modifier uses is the top bit of the selected field, not bit 31 of the word. Combinations that have no meaning for the tagged kind raise an error flag instead of producing a value.

Each operand is captured by one input register stage when `in_valid` is high. The conditioned word and its error flag are presented in the next cycle, together with `out_valid`. A two-state controller tracks whether the output holds a fresh result:
- State `ST_IDLE` moves to `ST_LOADED` on a cycle with `in_valid`.
- State `ST_LOADED` stays in `ST_LOADED` while `in_valid` keeps arriving.
- State `ST_LOADED` returns to `ST_IDLE` on a cycle without it.
- `ST_IDLE` stays in `ST_IDLE` while no input arrives.

The conditioned word is computed from the registered fields, so it holds its value until the next capture.

Top module: `subword_operand_cond`

## Requirements
- R1: After reset, `out_valid`, `out_err` and `out_data` are all zero.
- R2: `out_valid` is high in exactly the cycle after each clock edge at which `in_valid` was high. While `in_valid` stays low, `out_data` and `out_err` hold their last values.
- R3: Select codes 0 to 3 pick byte n (bits 8n+7 down to 8n). Code 4 picks bits 15:0, code 5 picks bits 31:16 and code 6 picks the full word. With no modifier the field is zero-extended.
- R4: Any select code above 6 raises `out_err`.
- R5: The kind tag is 0 for unsigned integer, 1 for signed integer and 2 for floating point. Tag 3 raises `out_err`.
- R6: For an unsigned operand, a set negate or sign-extend flag raises `out_err`. The absolute flag has no effect on an unsigned operand.
- R7: For a signed operand with the absolute flag set and the field's top bit set, the result is the two's-complement magnitude of the sign-extended field, truncated to 32 bits. When the field's top bit is clear, the absolute flag leaves the field unchanged.
- R8: For a signed operand with the negate flag set, the value left after the absolute step is sign-extended from the field's top bit and then negated (two's complement, 32 bits).
- R9: For a signed operand with the sign-extend flag set, the value left after the negate step is sign-extended from the field's top bit; this step is applied last.
- R10: For a floating-point operand, the absolute flag clears the field's top bit and keeps the lower bits of the field.
- R11: For a floating-point operand, the negate flag flips the field's top bit; it is applied after the absolute step.
- R12: For a floating-point operand, a set sign-extend flag raises `out_err`.
- R13: Whenever `out_err` is high, `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture the operand fields this cycle |
| in_data | input | DATA_W | Source word |
| in_sel | input | SEL_W | Field select code |
| in_type | input | 2 | Operand kind: 0 unsigned, 1 signed, 2 float, 3 reserved |
| in_sext | input | 1 | Sign-extend flag |
| in_neg | input | 1 | Negate flag |
| in_abs | input | 1 | Absolute-value flag |
| out_valid | output | 1 | Result presented this cycle |
| out_data | output | DATA_W | Conditioned operand |
| out_err | output | 1 | Illegal select, kind or modifier combination |

## Verification
The bench builds the block with its default 32-bit word. That gives a 3-bit select, in which code 7 is the only out-of-range value, and field top bits at 7, 15 and 31. All three sign positions are therefore exercised with modifier stacking, including the most-negative byte, whose magnitude wraps back to itself. Back-to-back and gapped captures check the one-cycle valid timing and the hold behaviour between results.

// File: rtl/swsel_pkg.sv
package swsel_pkg;

    typedef enum logic [1:0] {
        KIND_UINT  = 2'd0,
        KIND_SINT  = 2'd1,
        KIND_FLOAT = 2'd2,
        KIND_RSVD  = 2'd3
    } opnd_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic sext;
        logic neg;
        logic abs_v;
    } mod_flags_t;

endpackage

// File: rtl/swsel_field.sv
module swsel_field #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [DATA_W-1:0] field_o,
    output logic [IDX_W-1:0]  top_o,
    output logic              bad_o
);
    localparam int NB   = DATA_W / 8;
    localparam int NH   = DATA_W / 16;
    localparam int FULL = NB + NH;

    logic [DATA_W-1:0] cand [FULL+1];
    logic [IDX_W-1:0]  tops [FULL+1];

    genvar g;
    for (g = 0; g < NB; g++) begin : g_byte
        assign cand[g] = {{(DATA_W-8){1'b0}}, data_i[8*g +: 8]};
        assign tops[g] = IDX_W'(7);
    end
    for (g = 0; g < NH; g++) begin : g_half
        assign cand[NB+g] = {{(DATA_W-16){1'b0}}, data_i[16*g +: 16]};
        assign tops[NB+g] = IDX_W'(15);
    end
    assign cand[FULL] = data_i;
    assign tops[FULL] = IDX_W'(DATA_W-1);

    always_comb begin
        field_o = '0;
        top_o   = '0;
        bad_o   = 1'b1;
        for (int k = 0; k <= FULL; k++) begin
            if (int'(sel_i) == k) begin
                field_o = cand[k];
                top_o   = tops[k];
                bad_o   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/swsel_mod.sv
module swsel_mod
    import swsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] field_i,
    input  logic [IDX_W-1:0]  top_i,
    input  opnd_kind_e        kind_i,
    input  mod_flags_t        flags_i,
    output logic [DATA_W-1:0] word_o,
    output logic              err_o
);
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] below_mask;
    logic [DATA_W-1:0] top_bit;
    logic [DATA_W-1:0] st_abs;
    logic [DATA_W-1:0] st_neg;

    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                                input logic [DATA_W-1:0] m,
                                                input logic              s);
        return s ? (v | ~m) : (v & m);
    endfunction

    always_comb begin
        keep_mask  = (DATA_W'(2) << top_i) - DATA_W'(1);
        below_mask = (DATA_W'(1) << top_i) - DATA_W'(1);
        top_bit    = DATA_W'(1) << top_i;
        st_abs     = field_i;
        st_neg     = field_i;
        word_o     = field_i;
        err_o      = 1'b0;
        unique case (kind_i)
            KIND_UINT: begin
                err_o  = flags_i.sext | flags_i.neg;
                word_o = field_i;
            end
            KIND_SINT: begin
                st_abs = (flags_i.abs_v && field_i[top_i])
                       ? (DATA_W'(0) - widen(field_i, keep_mask, 1'b1))
                       : field_i;
                st_neg = flags_i.neg
                       ? (DATA_W'(0) - widen(st_abs, keep_mask, st_abs[top_i]))
                       : st_abs;
                word_o = flags_i.sext
                       ? widen(st_neg, keep_mask, st_neg[top_i])
                       : st_neg;
            end
            KIND_FLOAT: begin
                err_o  = flags_i.sext;
                st_abs = flags_i.abs_v ? (field_i & below_mask) : field_i;
                st_neg = flags_i.neg ? (st_abs ^ top_bit) : st_abs;
                word_o = st_neg;
            end
            KIND_RSVD: begin
                err_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/swsel_ctrl.sv
module swsel_ctrl
    import swsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid_i,
    output logic load_o,
    output logic valid_o
);
    ctrl_state_e state_q;
    ctrl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid_i ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid_i ? ST_LOADED : ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = in_valid_i;
        valid_o = (state_q == ST_LOADED);
    end

endmodule

// File: rtl/subword_operand_cond.sv
module subword_operand_cond
    import swsel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = $clog2(DATA_W/8 + DATA_W/16 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [1:0]        in_type,
    input  logic              in_sext,
    input  logic              in_neg,
    input  logic              in_abs,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);
    localparam int IDX_W = $clog2(DATA_W);

    logic              load;
    logic [DATA_W-1:0] data_q;
    logic [SEL_W-1:0]  sel_q;
    opnd_kind_e        kind_q;
    mod_flags_t        flags_q;

    logic [DATA_W-1:0] field;
    logic [IDX_W-1:0]  top_idx;
    logic              sel_bad;
    logic [DATA_W-1:0] mod_word;
    logic              mod_err;

    swsel_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid),
        .load_o     (load),
        .valid_o    (out_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            sel_q   <= '0;
            kind_q  <= KIND_UINT;
            flags_q <= '0;
        end else if (load) begin
            data_q  <= in_data;
            sel_q   <= in_sel;
            kind_q  <= opnd_kind_e'(in_type);
            flags_q <= '{sext: in_sext, neg: in_neg, abs_v: in_abs};
        end
    end

    swsel_field #(.DATA_W(DATA_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_field (
        .data_i  (data_q),
        .sel_i   (sel_q),
        .field_o (field),
        .top_o   (top_idx),
        .bad_o   (sel_bad)
    );

    swsel_mod #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mod (
        .field_i (field),
        .top_i   (top_idx),
        .kind_i  (kind_q),
        .flags_i (flags_q),
        .word_o  (mod_word),
        .err_o   (mod_err)
    );

    always_comb begin
        out_err  = sel_bad | mod_err;
        out_data = out_err ? '0 : mod_word;
    end

endmodule

// File: rtl/swsel_cond_checker.sv
module swsel_cond_checker #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [SEL_W-1:0]  in_sel,
    input logic [1:0]        in_type,
    input logic              in_sext,
    input logic              in_neg,
    input logic              in_abs,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_err
);
    localparam int FULL = DATA_W/8 + DATA_W/16;

    p_valid_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_result_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_err)));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd0 && !in_neg && !in_sext && in_sel == '0)
        |=> (out_data[DATA_W-1:8] == '0 && out_data[7:0] == $past(in_data[7:0]) && !out_err));

    p_bad_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_sel) > FULL) |=> out_err);

    p_bad_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd3) |=> out_err);

    p_uint_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd0 && (in_neg || in_sext)) |=> out_err);

    p_uint_abs_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd0 && in_abs && !in_neg && !in_sext && int'(in_sel) == FULL)
        |=> (out_data == $past(in_data) && !out_err));

    p_float_sext_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd2 && in_sext) |=> out_err);

    p_err_clears_word_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type == 2'd3) |=> out_data == '0);

endmodule

bind subword_operand_cond swsel_cond_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sel    (in_sel),
    .in_type   (in_type),
    .in_sext   (in_sext),
    .in_neg    (in_neg),
    .in_abs    (in_abs),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_err   (out_err)
);

// File: tb/subword_operand_cond_test.sv
`timescale 1ns/1ps
module subword_operand_cond_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [2:0]  in_sel = '0;
    logic [1:0]  in_type = '0;
    logic        in_sext = 1'b0;
    logic        in_neg = 1'b0;
    logic        in_abs = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    subword_operand_cond uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sel(in_sel), .in_type(in_type), .in_sext(in_sext), .in_neg(in_neg),
        .in_abs(in_abs), .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [31:0] sxm(input logic [31:0] v, input int hb);
        logic [31:0] t;
        t = v << (31 - hb);
        return 32'($signed(t) >>> (31 - hb));
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] d, input logic [2:0] s,
                                             input logic [1:0] k, input bit sx, input bit ng,
                                             input bit ab, output bit err);
        logic [31:0] f;
        int hb;
        err = 1'b0;
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: begin f = (d >> (8 * int'(s))) & 32'hFF; hb = 7; end
            3'd4: begin f = d & 32'hFFFF; hb = 15; end
            3'd5: begin f = d >> 16; hb = 15; end
            3'd6: begin f = d; hb = 31; end
            default: begin err = 1'b1; return 32'd0; end
        endcase
        case (k)
            2'd0: err = sx | ng;
            2'd1: begin
                if (ab && f[hb]) f = -sxm(f, hb);
                if (ng) f = -sxm(f, hb);
                if (sx) f = sxm(f, hb);
            end
            2'd2: begin
                err = sx;
                if (ab) f = f & ~(32'd1 << hb);
                if (ng) f = f ^ (32'd1 << hb);
            end
            default: err = 1'b1;
        endcase
        return err ? 32'd0 : f;
    endfunction

    task automatic drive(input logic [31:0] d, input logic [2:0] s, input logic [1:0] k,
                         input bit sx, input bit ng, input bit ab);
        @(negedge clk);
        in_data = d; in_sel = s; in_type = k;
        in_sext = sx; in_neg = ng; in_abs = ab; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] exp_w, input bit exp_e,
                         input bit exp_v);
        n_chk++;
        if (out_data !== exp_w || out_err !== exp_e || out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got data=%h err=%b valid=%b, expected data=%h err=%b valid=%b",
                     tag, out_data, out_err, out_valid, exp_w, exp_e, exp_v);
        end
    endtask

    task automatic run_model(input string tag, input logic [31:0] d, input logic [2:0] s,
                             input logic [1:0] k, input bit sx, input bit ng, input bit ab);
        bit e;
        logic [31:0] w;
        w = ref_word(d, s, k, sx, ng, ab, e);
        drive(d, s, k, sx, ng, ab);
        check(tag, w, e, 1'b1);
    endtask

    task automatic run_lit(input string tag, input logic [31:0] d, input logic [2:0] s,
                           input logic [1:0] k, input bit sx, input bit ng, input bit ab,
                           input logic [31:0] exp_w, input bit exp_e);
        drive(d, s, k, sx, ng, ab);
        check(tag, exp_w, exp_e, 1'b1);
    endtask

    task automatic t_reset_r1();
        check("R1 reset state", 32'd0, 1'b0, 1'b0);
    endtask

    task automatic t_select_r3();
        run_lit("R3 byte0", 32'hA1B2C3D4, 3'd0, 2'd0, 0, 0, 0, 32'h000000D4, 0);
        run_lit("R3 byte3", 32'hA1B2C3D4, 3'd3, 2'd0, 0, 0, 0, 32'h000000A1, 0);
        run_lit("R3 half hi", 32'hA1B2C3D4, 3'd5, 2'd0, 0, 0, 0, 32'h0000A1B2, 0);
        for (int s = 0; s < 7; s++) begin
            run_model("R3 sweep", 32'h8F7E6D5C, 3'(s), 2'd1, 0, 0, 0);
        end
    endtask

    task automatic t_badsel_r4();
        run_lit("R4 select 7", 32'hFFFFFFFF, 3'd7, 2'd0, 0, 0, 0, 32'd0, 1);
    endtask

    task automatic t_kind_r5();
        run_lit("R5 reserved kind", 32'h12345678, 3'd6, 2'd3, 0, 0, 0, 32'd0, 1);
        run_lit("R13 reserved kind zero word", 32'h000000FF, 3'd0, 2'd3, 0, 0, 1, 32'd0, 1);
    endtask

    task automatic t_unsigned_r6();
        run_lit("R6 uint neg", 32'h00000005, 3'd0, 2'd0, 0, 1, 0, 32'd0, 1);
        run_lit("R6 uint sext", 32'h00000085, 3'd0, 2'd0, 1, 0, 0, 32'd0, 1);
        run_lit("R6 uint abs inert", 32'h000000F6, 3'd0, 2'd0, 0, 0, 1, 32'h000000F6, 0);
    endtask

    task automatic t_sabs_r7();
        run_lit("R7 sint abs byte -10", 32'h000000F6, 3'd0, 2'd1, 0, 0, 1, 32'h0000000A, 0);
        run_lit("R7 sint abs byte 0x80", 32'h00000080, 3'd0, 2'd1, 0, 0, 1, 32'h00000080, 0);
        run_lit("R7 sint abs positive", 32'h00003000, 3'd1, 2'd1, 0, 0, 1, 32'h00000030, 0);
        run_model("R7 sint abs half", 32'h8001FFFF, 3'd5, 2'd1, 0, 0, 1);
    endtask

    task automatic t_sneg_r8();
        run_lit("R8 sint neg byte 5", 32'h00000500, 3'd1, 2'd1, 0, 1, 0, 32'hFFFFFFFB, 0);
        run_lit("R8 sint neg full", 32'h00000001, 3'd6, 2'd1, 0, 1, 0, 32'hFFFFFFFF, 0);
        run_model("R8 sint abs then neg", 32'h0000FF9C, 3'd4, 2'd1, 0, 1, 1);
    endtask

    task automatic t_ssext_r9();
        run_lit("R9 sint sext half", 32'h80000000, 3'd5, 2'd1, 1, 0, 0, 32'hFFFF8000, 0);
        run_lit("R9 sint abs then sext", 32'h00000080, 3'd0, 2'd1, 1, 0, 1, 32'hFFFFFF80, 0);
        run_model("R9 sint all flags", 32'h00C30000, 3'd2, 2'd1, 1, 1, 1);
    endtask

    task automatic t_fabs_r10();
        run_lit("R10 float abs half", 32'h0000BC00, 3'd4, 2'd2, 0, 0, 1, 32'h00003C00, 0);
        run_lit("R10 float abs full", 32'hC0490FDB, 3'd6, 2'd2, 0, 0, 1, 32'h40490FDB, 0);
    endtask

    task automatic t_fneg_r11();
        run_lit("R11 float neg half", 32'h3C000000, 3'd5, 2'd2, 0, 1, 0, 32'h0000BC00, 0);
        run_lit("R11 float abs then neg", 32'h0000BC00, 3'd4, 2'd2, 0, 1, 1, 32'h0000BC00, 0);
        run_lit("R11 float neg byte", 32'h00000012, 3'd0, 2'd2, 0, 1, 0, 32'h00000092, 0);
    endtask

    task automatic t_fsext_r12();
        run_lit("R12 float sext", 32'h0000BC00, 3'd4, 2'd2, 1, 0, 0, 32'd0, 1);
    endtask

    task automatic t_timing_r2();
        run_lit("R2 load", 32'h000000AB, 3'd0, 2'd0, 0, 0, 0, 32'h000000AB, 0);
        @(negedge clk);
        check("R2 idle holds", 32'h000000AB, 1'b0, 1'b0);
        @(negedge clk);
        in_data = 32'h0000CD00; in_sel = 3'd1; in_type = 2'd0;
        in_sext = 0; in_neg = 0; in_abs = 0; in_valid = 1'b1;
        @(negedge clk);
        check("R2 back-to-back first", 32'h000000CD, 1'b0, 1'b1);
        in_data = 32'h00000000; in_sel = 3'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 back-to-back second", 32'd0, 1'b1, 1'b1);
        in_sel = 3'd0; in_data = 32'h11111111;
        @(negedge clk);
        check("R2 ignored inputs while idle", 32'd0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected finish before timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_select_r3();
        t_badsel_r4();
        t_kind_r5();
        t_unsigned_r6();
        t_sabs_r7();
        t_sneg_r8();
        t_ssext_r9();
        t_fabs_r10();
        t_fneg_r11();
        t_fsext_r12();
        t_timing_r2();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule